// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains one transmit descriptor ring held in a word-addressed memory. Software sets up the ring by giving the word address of its first slot, the number of slots, and a head index that points one past the last descriptor it has handed over. The engine owns a tail index. While its channel is enabled and the tail differs from the head, it reads the descriptor at the tail and presents the frame length, the start and end codes, the isochronous flag and the 64-bit buffer address on a frame request interface. It then waits for a done handshake, writes the control word back with the completed flag set, and advances the tail. Both indices wrap at the slot count.

Each descriptor takes four 32-bit words: word 0 and word 1 hold the low and high halves of the buffer address, word 2 is the control word and word 3 is a time word that the engine never touches. In the control word, bits 11:0 are the length, 15:12 the end-of-frame code, 19:16 the start-of-frame code and 31:20 the flags. Within the flags, bit 20 is isochronous, bit 21 is completed, bit 22 is posted and bit 23 asks for an interrupt. The memory answers a read with data one cycle after the request, and a write takes effect at the clock edge that ends the request cycle.

Top module: `txring_engine`

## Requirements
- R1: After reset the tail is 0, and `irq`, `err_unposted`, `frm_valid` and `mem_req` are all low.
- R2: No memory request is made while the engine is idle and either `cfg_enable` is low, the tail equals `cfg_head`, or `cfg_count` is 0.
- R3: A descriptor is fetched with three reads on consecutive cycles, at word addresses base+4*tail+0, +1 and +2.
- R4: The frame request carries address {word1,word0}, length word2[11:0], end code word2[15:12], start code word2[19:16] and isochronous flag word2[20], and holds them with `frm_valid` high until `frm_done` is seen high.
- R5: The cycle after the done handshake, exactly one write goes to base+4*tail+2 with the fetched word 2 and bit 21 set, every other bit unchanged; words 0, 1 and 3 are never written.
- R6: The tail changes only in the cycle after a write-back and then steps by one, going from count-1 to 0.
- R7: `irq` is high for exactly one cycle, the cycle after a write-back, and only when word 2 bit 23 of that descriptor is set.
- R8: A descriptor with bit 22 clear is still sent and written back, and `err_unposted` rises after its write-back and stays high until reset.
- R9: If `cfg_enable` falls while a descriptor is in progress, that descriptor is completed and written back, and no further descriptor is fetched until enable rises again.
- R10: Descriptors are processed in ring order until the tail reaches the head; a later head move or enable rise restarts the walk from the current tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel run enable |
| cfg_base | input | ADDR_W | Word address of ring slot 0 |
| cfg_count | input | IDX_W | Number of ring slots |
| cfg_head | input | IDX_W | Software head index |
| ring_tail | output | IDX_W | Engine tail index |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| frm_valid | output | 1 | Frame request valid |
| frm_addr | output | 64 | Frame buffer address |
| frm_len | output | 12 | Frame length |
| frm_eof | output | 4 | End-of-frame code |
| frm_sof | output | 4 | Start-of-frame code |
| frm_isoch | output | 1 | Isochronous flag |
| frm_done | input | 1 | Frame done handshake |
| irq | output | 1 | One-cycle interrupt request |
| err_unposted | output | 1 | Sticky unposted-descriptor flag |

## Verification
The completion of the descriptor in flight and a fall of the run enable can land in the same window, and the outcome depends on which one the engine honours first. The bench slows the done handshake, drops enable while a frame request is pending, and then judges the result at the ports: exactly one frame, one write-back, three reads and a tail that moved by one, followed by silence until enable returns and the rest of the ring drains. A second overlap, the interrupt pulse of one descriptor falling beside the next fetch, is judged by matching each pulse against the write-back one cycle earlier.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W      = 32;
  localparam int SLOT_SHIFT  = 2;   // four words per descriptor
  localparam int CTRL_OFS    = 2;   // control word position within a slot
  localparam int LEN_W       = 12;
  localparam int CODE_W      = 4;
  localparam int EOF_LSB     = 12;
  localparam int SOF_LSB     = 16;
  localparam int BIT_ISOCH   = 20;
  localparam int BIT_DONE    = 21;
  localparam int BIT_POSTED  = 22;
  localparam int BIT_IRQ     = 23;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_RD0  = 3'd1,
    SQ_RD1  = 3'd2,
    SQ_RD2  = 3'd3,
    SQ_CAP  = 3'd4,
    SQ_REQ  = 3'd5,
    SQ_WB   = 3'd6
  } sq_state_t;
endpackage

// File: rtl/txr_rst_sync.sv
module txr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/txr_tail_ptr.sv
module txr_tail_ptr #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] count,
  output logic [IDX_W-1:0] tail
);
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [IDX_W:0]   inc;
  logic             wrap;

  always_comb begin
    inc    = {1'b0, tail_q} + 1'b1;
    wrap   = (inc >= {1'b0, count});
    tail_d = wrap ? '0 : inc[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tail_q <= '0;
    else if (step) tail_q <= tail_d;
  end

  assign tail = tail_q;
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  count,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  tail,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              frm_valid,
  output logic [2*WORD_W-1:0] frm_addr,
  output logic [LEN_W-1:0]  frm_len,
  output logic [CODE_W-1:0] frm_eof,
  output logic [CODE_W-1:0] frm_sof,
  output logic              frm_isoch,
  input  logic              frm_done,
  output logic              wb_fire,
  output logic              desc_irq,
  output logic              desc_unposted,
  output logic              busy
);
  sq_state_t        state_q, state_d;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q;
  logic             w0_en, w1_en, w2_en;
  logic             start;
  logic [ADDR_W-1:0] slot_addr;
  logic [ADDR_W-1:0] word_ofs;

  assign start = enable && (head != tail) && (count != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (start) state_d = SQ_RD0;
      SQ_RD0:  state_d = SQ_RD1;
      SQ_RD1:  state_d = SQ_RD2;
      SQ_RD2:  state_d = SQ_CAP;
      SQ_CAP:  state_d = SQ_REQ;
      SQ_REQ:  if (frm_done) state_d = SQ_WB;
      SQ_WB:   state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  // read data lags the request by one cycle
  assign w0_en = (state_q == SQ_RD1);
  assign w1_en = (state_q == SQ_RD2);
  assign w2_en = (state_q == SQ_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      w1_q <= '0;
      w2_q <= '0;
    end else begin
      if (w0_en) w0_q <= mem_rdata;
      if (w1_en) w1_q <= mem_rdata;
      if (w2_en) w2_q <= mem_rdata;
    end
  end

  always_comb begin
    unique case (state_q)
      SQ_RD1:        word_ofs = ADDR_W'(1);
      SQ_RD2, SQ_WB: word_ofs = ADDR_W'(CTRL_OFS);
      default:       word_ofs = '0;
    endcase
  end

  assign slot_addr = base + (ADDR_W'(tail) << SLOT_SHIFT);
  assign mem_addr  = slot_addr + word_ofs;
  assign mem_req   = (state_q == SQ_RD0) || (state_q == SQ_RD1) ||
                     (state_q == SQ_RD2) || (state_q == SQ_WB);
  assign mem_we    = (state_q == SQ_WB);
  assign mem_wdata = w2_q | (WORD_W'(1) << BIT_DONE);

  assign frm_valid = (state_q == SQ_REQ);
  assign frm_addr  = {w1_q, w0_q};
  assign frm_len   = w2_q[LEN_W-1:0];
  assign frm_eof   = w2_q[EOF_LSB +: CODE_W];
  assign frm_sof   = w2_q[SOF_LSB +: CODE_W];
  assign frm_isoch = w2_q[BIT_ISOCH];

  assign wb_fire       = (state_q == SQ_WB);
  assign desc_irq      = w2_q[BIT_IRQ];
  assign desc_unposted = !w2_q[BIT_POSTED];
  assign busy          = (state_q != SQ_IDLE);
endmodule

// File: rtl/txr_notify.sv
module txr_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic wb_fire,
  input  logic desc_irq,
  input  logic desc_unposted,
  output logic irq,
  output logic err_unposted
);
  logic irq_q, irq_d;
  logic err_q, err_d;

  always_comb begin
    irq_d = wb_fire && desc_irq;
    err_d = err_q || (wb_fire && desc_unposted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end

  assign irq          = irq_q;
  assign err_unposted = err_q;
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_count,
  input  logic [IDX_W-1:0]  cfg_head,
  output logic [IDX_W-1:0]  ring_tail,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              frm_valid,
  output logic [63:0]       frm_addr,
  output logic [11:0]       frm_len,
  output logic [3:0]        frm_eof,
  output logic [3:0]        frm_sof,
  output logic              frm_isoch,
  input  logic              frm_done,
  output logic              irq,
  output logic              err_unposted
);
  logic rst_int_n;
  logic wb_fire, desc_irq, desc_unposted, seq_busy;

  txr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  txr_tail_ptr #(.IDX_W(IDX_W)) u_tail (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (wb_fire),
    .count (cfg_count),
    .tail  (ring_tail)
  );

  txr_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .enable        (cfg_enable),
    .base          (cfg_base),
    .count         (cfg_count),
    .head          (cfg_head),
    .tail          (ring_tail),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .frm_valid     (frm_valid),
    .frm_addr      (frm_addr),
    .frm_len       (frm_len),
    .frm_eof       (frm_eof),
    .frm_sof       (frm_sof),
    .frm_isoch     (frm_isoch),
    .frm_done      (frm_done),
    .wb_fire       (wb_fire),
    .desc_irq      (desc_irq),
    .desc_unposted (desc_unposted),
    .busy          (seq_busy)
  );

  txr_notify u_notify (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wb_fire       (wb_fire),
    .desc_irq      (desc_irq),
    .desc_unposted (desc_unposted),
    .irq           (irq),
    .err_unposted  (err_unposted)
  );
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             enable,
  input logic [IDX_W-1:0] tail,
  input logic [IDX_W-1:0] head,
  input logic             mem_req,
  input logic             mem_we,
  input logic             frm_valid,
  input logic             frm_done,
  input logic [11:0]      frm_len,
  input logic             irq,
  input logic             err
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!enable || tail == head)) |=> !mem_req);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_done) |=> (frm_valid && $stable(frm_len)));

  p_wb_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_done) |=> (mem_req && mem_we));

  p_tail_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tail) |-> $past(mem_req && mem_we));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req && mem_we));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind txring_engine txr_chk #(.IDX_W(IDX_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (seq_busy),
  .enable    (cfg_enable),
  .tail      (ring_tail),
  .head      (cfg_head),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .frm_valid (frm_valid),
  .frm_done  (frm_done),
  .frm_len   (frm_len),
  .irq       (irq),
  .err       (err_unposted)
);

// File: tb/test_txring_engine.sv
module test_txring_engine;
  localparam int AW = 16;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_enable;
  logic [AW-1:0] cfg_base;
  logic [IW-1:0] cfg_count;
  logic [IW-1:0] cfg_head;
  logic [IW-1:0] ring_tail;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;
  logic          frm_valid;
  logic [63:0]   frm_addr;
  logic [11:0]   frm_len;
  logic [3:0]    frm_eof, frm_sof;
  logic          frm_isoch;
  logic          frm_done;
  logic          irq, err_unposted;

  always #5 clk = ~clk;

  txring_engine #(.ADDR_W(AW), .IDX_W(IW)) i_txring_engine (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
    .cfg_count(cfg_count), .cfg_head(cfg_head), .ring_tail(ring_tail),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .frm_valid(frm_valid),
    .frm_addr(frm_addr), .frm_len(frm_len), .frm_eof(frm_eof),
    .frm_sof(frm_sof), .frm_isoch(frm_isoch), .frm_done(frm_done),
    .irq(irq), .err_unposted(err_unposted)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: read data one cycle after request
  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // frame completion responder
  int done_lat = 2;
  int dcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_done <= 1'b0;
      dcnt     <= 0;
    end else if (frm_valid && !frm_done) begin
      if (dcnt >= done_lat) begin
        frm_done <= 1'b1;
        dcnt     <= 0;
      end else dcnt <= dcnt + 1;
    end else frm_done <= 1'b0;
  end

  // monitor logs
  int          n_frm, n_wb, n_rd, n_irq;
  logic [63:0] f_addr [0:15];
  logic [11:0] f_len  [0:15];
  logic [3:0]  f_eof  [0:15];
  logic [3:0]  f_sof  [0:15];
  logic        f_iso  [0:15];
  logic [AW-1:0] wb_addr [0:15];
  logic [31:0]   wb_data [0:15];
  int          exp_tail, rd_k;
  bit          pend_wb, pend_irq;

  function automatic int wrap_inc(input int t, input int c);
    return (t + 1 >= c) ? 0 : t + 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_wb) begin
        pend_wb = 0;
        check(irq == pend_irq, "R7 irq after write-back", 64'(irq), 64'(pend_irq));
        check(ring_tail == IW'(exp_tail), "R6 tail after write-back",
              64'(ring_tail), 64'(exp_tail));
      end else if (irq) begin
        check(1'b0, "R7 stray irq", 64'(irq), 64'd0);
      end
      if (irq) n_irq++;
      if (mem_req && !mem_we) begin
        check(mem_addr == AW'(cfg_base + 4 * exp_tail + rd_k), "R3 read address",
              64'(mem_addr), 64'(cfg_base + 4 * exp_tail + rd_k));
        n_rd++;
        rd_k = (rd_k + 1) % 3;
      end
      if (mem_req && mem_we) begin
        if (n_wb < 16) begin
          wb_addr[n_wb] = mem_addr;
          wb_data[n_wb] = mem_wdata;
        end
        pend_irq = mem[mem_addr[7:0]][23];
        exp_tail = wrap_inc(exp_tail, int'(cfg_count));
        pend_wb  = 1;
        n_wb++;
      end
      if (frm_valid && frm_done) begin
        if (n_frm < 16) begin
          f_addr[n_frm] = frm_addr;
          f_len[n_frm]  = frm_len;
          f_eof[n_frm]  = frm_eof;
          f_sof[n_frm]  = frm_sof;
          f_iso[n_frm]  = frm_isoch;
        end
        n_frm++;
      end
    end
  end

  function automatic logic [31:0] ctrl_word(input int len, input int eofc, input int sofc,
                                            input bit iso, input bit posted, input bit irqb);
    logic [11:0] flags;
    flags = {8'd0, irqb, posted, 1'b0, iso};
    return {flags, 4'(sofc), 4'(eofc), 12'(len)};
  endfunction

  task automatic load_desc(input int base, input int idx, input logic [31:0] ctrl);
    mem[8'(base + 4 * idx + 0)] = 32'hA500_0000 + 32'(idx);
    mem[8'(base + 4 * idx + 1)] = 32'h0000_0C00 + 32'(idx);
    mem[8'(base + 4 * idx + 2)] = ctrl;
    mem[8'(base + 4 * idx + 3)] = 32'h0000_0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_enable = 1'b0;
    cfg_head = '0;
    n_frm = 0; n_wb = 0; n_rd = 0; n_irq = 0;
    exp_tail = 0; rd_k = 0; pend_wb = 0; pend_irq = 0;
    done_lat = 2;
    for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    cfg_base = 16'h0010; cfg_count = 8'd8;
    do_reset();
    check(ring_tail == 0, "R1 tail", 64'(ring_tail), 64'd0);
    check(!irq && !err_unposted, "R1 irq/err", {62'd0, irq, err_unposted}, 64'd0);
    check(!frm_valid && !mem_req, "R1 valid/req", {62'd0, frm_valid, mem_req}, 64'd0);
  endtask

  task automatic t_idle();
    cfg_base = 16'h0010; cfg_count = 8'd8;
    do_reset();
    load_desc(16, 0, ctrl_word(10, 1, 2, 0, 1, 0));
    load_desc(16, 1, ctrl_word(11, 1, 2, 0, 1, 0));
    cfg_enable = 1'b1; cfg_head = 8'd0;
    repeat (20) @(negedge clk);
    check(n_rd == 0, "R2 empty ring makes no read", 64'(n_rd), 64'd0);
    cfg_enable = 1'b0; cfg_head = 8'd2;
    repeat (20) @(negedge clk);
    check(n_rd == 0, "R2 disabled ring makes no read", 64'(n_rd), 64'd0);
    cfg_enable = 1'b1;
    repeat (60) @(negedge clk);
    check(n_frm == 2, "R10 enable rise drains ring", 64'(n_frm), 64'd2);
    check(ring_tail == 2, "R10 tail reaches head", 64'(ring_tail), 64'd2);
  endtask

  task automatic t_basic();
    logic [31:0] c [0:3];
    cfg_base = 16'h0020; cfg_count = 8'd8;
    do_reset();
    c[0] = ctrl_word(12'h040, 4'h1, 4'h2, 0, 1, 0);
    c[1] = ctrl_word(12'h7FF, 4'hA, 4'h5, 1, 1, 1);
    c[2] = ctrl_word(12'h001, 4'hF, 4'h0, 0, 1, 0);
    c[3] = ctrl_word(12'hFFF, 4'h3, 4'hC, 1, 1, 1);
    for (int i = 0; i < 4; i++) load_desc(32, i, c[i]);
    cfg_enable = 1'b1; cfg_head = 8'd4;
    repeat (100) @(negedge clk);
    check(n_frm == 4, "R10 frames sent", 64'(n_frm), 64'd4);
    for (int i = 0; i < 4; i++) begin
      check(f_addr[i] == {32'h0000_0C00 + 32'(i), 32'hA500_0000 + 32'(i)},
            "R4 frame address", f_addr[i], {32'h0000_0C00 + 32'(i), 32'hA500_0000 + 32'(i)});
      check(f_len[i] == c[i][11:0], "R4 frame length", 64'(f_len[i]), 64'(c[i][11:0]));
      check(f_eof[i] == c[i][15:12] && f_sof[i] == c[i][19:16], "R4 frame codes",
            {56'd0, f_sof[i], f_eof[i]}, {56'd0, c[i][19:16], c[i][15:12]});
      check(f_iso[i] == c[i][20], "R4 isochronous flag", 64'(f_iso[i]), 64'(c[i][20]));
      check(wb_addr[i] == AW'(32 + 4 * i + 2), "R5 write-back address",
            64'(wb_addr[i]), 64'(32 + 4 * i + 2));
      check(wb_data[i] == (c[i] | 32'h0020_0000), "R5 write-back data",
            64'(wb_data[i]), 64'(c[i] | 32'h0020_0000));
      check(mem[8'(32 + 4 * i + 3)] == 0 && mem[8'(32 + 4 * i)] == 32'hA500_0000 + 32'(i),
            "R5 other words untouched", 64'(mem[8'(32 + 4 * i + 3)]), 64'd0);
    end
    check(n_wb == 4, "R5 one write per descriptor", 64'(n_wb), 64'd4);
    check(n_irq == 2, "R7 irq count", 64'(n_irq), 64'd2);
    check(ring_tail == 4, "R6 final tail", 64'(ring_tail), 64'd4);
    check(!err_unposted, "R8 no error when all posted", 64'(err_unposted), 64'd0);
  endtask

  task automatic t_wrap();
    cfg_base = 16'h0040; cfg_count = 8'd3;
    do_reset();
    for (int i = 0; i < 3; i++) load_desc(64, i, ctrl_word(20 + i, 2, 3, 0, 1, 1));
    cfg_enable = 1'b1; cfg_head = 8'd2;
    repeat (50) @(negedge clk);
    check(ring_tail == 2, "R6 tail before wrap", 64'(ring_tail), 64'd2);
    load_desc(64, 0, ctrl_word(99, 4, 5, 0, 1, 0));
    cfg_head = 8'd1;
    repeat (50) @(negedge clk);
    check(n_wb == 4, "R6 write-backs across wrap", 64'(n_wb), 64'd4);
    check(wb_addr[2] == AW'(64 + 8 + 2), "R6 slot before wrap", 64'(wb_addr[2]), 64'(74));
    check(wb_addr[3] == AW'(64 + 2), "R6 slot after wrap", 64'(wb_addr[3]), 64'(66));
    check(f_len[3] == 12'd99, "R10 wrapped descriptor sent", 64'(f_len[3]), 64'd99);
    check(ring_tail == 1, "R6 tail after wrap", 64'(ring_tail), 64'd1);
  endtask

  task automatic t_unposted();
    logic [31:0] c0;
    cfg_base = 16'h0060; cfg_count = 8'd4;
    do_reset();
    c0 = ctrl_word(33, 1, 1, 0, 0, 0);
    load_desc(96, 0, c0);
    load_desc(96, 1, ctrl_word(34, 1, 1, 0, 1, 0));
    cfg_enable = 1'b1; cfg_head = 8'd1;
    repeat (30) @(negedge clk);
    check(n_frm == 1 && f_len[0] == 12'd33, "R8 unposted still sent", 64'(n_frm), 64'd1);
    check(wb_data[0] == (c0 | 32'h0020_0000), "R8 unposted write-back",
          64'(wb_data[0]), 64'(c0 | 32'h0020_0000));
    check(err_unposted, "R8 error raised", 64'(err_unposted), 64'd1);
    cfg_head = 8'd2;
    repeat (30) @(negedge clk);
    check(err_unposted && n_frm == 2, "R8 error stays set", 64'(err_unposted), 64'd1);
  endtask

  task automatic t_disable();
    cfg_base = 16'h0080; cfg_count = 8'd8;
    do_reset();
    for (int i = 0; i < 5; i++) load_desc(128, i, ctrl_word(40 + i, 6, 7, 0, 1, 0));
    done_lat = 12;
    cfg_enable = 1'b1; cfg_head = 8'd5;
    while (!frm_valid) @(negedge clk);
    cfg_enable = 1'b0;
    repeat (40) @(negedge clk);
    check(n_frm == 1 && n_wb == 1, "R9 in-flight descriptor finished", 64'(n_wb), 64'd1);
    check(n_rd == 3, "R9 no further fetch", 64'(n_rd), 64'd3);
    check(ring_tail == 1, "R9 tail moved once", 64'(ring_tail), 64'd1);
    cfg_enable = 1'b1;
    repeat (200) @(negedge clk);
    check(n_frm == 5 && ring_tail == 5, "R10 resume after enable", 64'(ring_tail), 64'd5);
    check(f_len[4] == 12'd44, "R10 order kept", 64'(f_len[4]), 64'd44);
  endtask

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_head = '0;
    cfg_base = '0; cfg_count = 8'd8;
    t_reset();
    t_idle();
    t_basic();
    t_wrap();
    t_unposted();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule